// File: doc/BRIEF.md
# Tag-Waiting Reservation Station Array

This block holds a small pool of reservation stations that feed one execution unit. Operations come in one per cycle, in program order, with their destination and two source register numbers plus the two values that the register file returns for those sources in the same cycle. A register status table maps each architectural register either to "value present" (tag zero) or to the tag of the station that will produce its next value. An issued operation copies each source that is present. For each source that is not present it keeps the producer's tag, and it takes the value from the single result broadcast bus when that tag appears. The destination register is then renamed to the new station's tag.

Each station runs a four-state machine. FREE moves to READY on allocation when both sources are present, and to WAIT on allocation when either source is missing. WAIT moves to READY in the cycle the last missing tag is seen on the broadcast bus. READY moves to EXEC when the dispatch selector grants the station. EXEC moves back to FREE when the station's own tag is broadcast. Among the READY stations the selector picks the oldest, using an age rank that each station gets at allocation and that is reduced whenever an older station retires. The register file lives outside the block. The block drives a write port to it, and that port fires only when the broadcast tag is still the latest producer of a register.

Top module: `rs_tag_array`

## Requirements
- R1: After reset every station is FREE and every register reads as present: `iss_stall` is 0, `disp_valid` is 0, `rf_we` is 0 and `iss_tag` is 1.
- R2: Station k carries tag k+1. An issue is accepted when `iss_valid` is 1 and `iss_stall` is 0, and it takes the lowest-numbered free station, whose tag is shown on `iss_tag`. `iss_stall` is 1 exactly when no station is free.
- R3: A source whose status entry is zero is taken from `iss_src1_val` / `iss_src2_val` at issue.
- R4: A waiting station captures a missing operand from `cdb_value` in the cycle `cdb_valid` is 1 with the awaited tag, and never reads the register file for it.
- R5: When a source's producer tag is broadcast in the same cycle the consumer issues, the consumer takes the broadcast value at once and is dispatchable in the next cycle.
- R6: A station is dispatched only when both operands are present, exactly once, with its op, its tag and both operand values on the dispatch port.
- R7: When several stations are READY, the one allocated earliest is dispatched first.
- R8: On an accepted issue the destination register's status becomes the new tag, so later readers wait on that tag. A source equal to the same operation's destination uses the previous status.
- R9: A broadcast writes the register file (`rf_we`, `rf_waddr`, `rf_wdata`) only for the register whose status still names the broadcast tag, and that status returns to zero. An older producer of a renamed register writes nothing.
- R10: A station in EXEC becomes FREE in the cycle after its tag is broadcast, and it can be allocated again from that cycle.
- R11: For any stream of operations and result latencies, the final register file equals the one produced by executing the stream one operation at a time in program order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| iss_valid | input | 1 | Operation offered for issue |
| iss_op | input | OP_W | Operation code, carried through to dispatch |
| iss_dst | input | log2(NUM_REGS) | Destination register number |
| iss_src1 | input | log2(NUM_REGS) | First source register number |
| iss_src2 | input | log2(NUM_REGS) | Second source register number |
| iss_src1_val | input | DATA_W | Register file value of the first source, same cycle |
| iss_src2_val | input | DATA_W | Register file value of the second source, same cycle |
| iss_stall | output | 1 | No station free, issue not accepted |
| iss_tag | output | log2(NUM_RS+1) | Tag that an accepted issue receives this cycle |
| cdb_valid | input | 1 | Result broadcast valid |
| cdb_tag | input | log2(NUM_RS+1) | Tag of the broadcast result |
| cdb_value | input | DATA_W | Broadcast result value |
| disp_valid | output | 1 | An operation is sent to the execution unit |
| disp_tag | output | log2(NUM_RS+1) | Tag of the dispatched station |
| disp_op | output | OP_W | Operation code of the dispatched station |
| disp_a | output | DATA_W | First operand value |
| disp_b | output | DATA_W | Second operand value |
| rf_we | output | 1 | Register file write enable |
| rf_waddr | output | log2(NUM_REGS) | Register file write address |
| rf_wdata | output | DATA_W | Register file write data |

## Verification
A wrong capture or a wrong rename shows up as a bad operand value on the dispatch port in the first cycle the affected station is dispatched. Every dispatch is compared with the value that sequential execution gives at that point in the program. A bad age rank or a wrong selector shows up as the wrong `disp_tag` in the cycle two stations become READY together. A status table that names the wrong producer shows up either as a spurious or missing `rf_we` in the broadcast cycle, or later as a register file that differs from the sequential result once the stream has drained.

// File: rtl/rs_pkg.sv
package rs_pkg;

    // Life cycle of one reservation station
    typedef enum logic [1:0] {
        ST_FREE  = 2'd0,
        ST_WAIT  = 2'd1,
        ST_READY = 2'd2,
        ST_EXEC  = 2'd3
    } slot_state_e;

endpackage

// File: rtl/rs_station.sv
module rs_station
    import rs_pkg::*;
#(
    parameter int          TAG_W  = 3,
    parameter int          DATA_W = 16,
    parameter int          OP_W   = 2,
    parameter int          RANK_W = 2,
    parameter int unsigned MY_TAG = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alloc_i,
    input  logic [OP_W-1:0]   op_i,
    input  logic [DATA_W-1:0] v1_i,
    input  logic [TAG_W-1:0]  q1_i,
    input  logic [DATA_W-1:0] v2_i,
    input  logic [TAG_W-1:0]  q2_i,
    input  logic [RANK_W-1:0] rank_i,
    input  logic              cdb_valid_i,
    input  logic [TAG_W-1:0]  cdb_tag_i,
    input  logic [DATA_W-1:0] cdb_value_i,
    input  logic              grant_i,
    input  logic              shift_i,
    input  logic [RANK_W-1:0] shift_rank_i,
    output logic              busy_o,
    output logic              ready_o,
    output logic              retire_o,
    output logic [RANK_W-1:0] rank_o,
    output logic [OP_W-1:0]   op_o,
    output logic [DATA_W-1:0] v1_o,
    output logic [DATA_W-1:0] v2_o
);

    slot_state_e       state_q, state_d;
    logic [TAG_W-1:0]  q1_q, q2_q;
    logic [DATA_W-1:0] v1_q, v2_q;
    logic [OP_W-1:0]   op_q;
    logic [RANK_W-1:0] rank_q;
    logic              hit1, hit2, own_bcast;

    assign hit1      = cdb_valid_i && (q1_q != '0) && (cdb_tag_i == q1_q);
    assign hit2      = cdb_valid_i && (q2_q != '0) && (cdb_tag_i == q2_q);
    assign own_bcast = cdb_valid_i && (cdb_tag_i == TAG_W'(MY_TAG));

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_FREE: begin
                if (alloc_i) begin
                    state_d = ((q1_i == '0) && (q2_i == '0)) ? ST_READY : ST_WAIT;
                end
            end
            ST_WAIT: begin
                if (((q1_q == '0) || hit1) && ((q2_q == '0) || hit2)) begin
                    state_d = ST_READY;
                end
            end
            ST_READY: begin
                if (grant_i) begin
                    state_d = ST_EXEC;
                end
            end
            ST_EXEC: begin
                if (own_bcast) begin
                    state_d = ST_FREE;
                end
            end
            default: state_d = ST_FREE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_FREE;
        end else begin
            state_q <= state_d;
        end
    end

    // outputs
    always_comb begin
        busy_o   = (state_q != ST_FREE);
        ready_o  = (state_q == ST_READY);
        retire_o = (state_q == ST_EXEC) && own_bcast;
        rank_o   = rank_q;
        op_o     = op_q;
        v1_o     = v1_q;
        v2_o     = v2_q;
    end

    // operand and age storage
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_q   <= '0;
            v1_q   <= '0;
            v2_q   <= '0;
            q1_q   <= '0;
            q2_q   <= '0;
            rank_q <= '0;
        end else begin
            if (alloc_i && (state_q == ST_FREE)) begin
                op_q   <= op_i;
                v1_q   <= v1_i;
                q1_q   <= q1_i;
                v2_q   <= v2_i;
                q2_q   <= q2_i;
                rank_q <= rank_i;
            end else begin
                if (hit1) begin
                    v1_q <= cdb_value_i;
                    q1_q <= '0;
                end
                if (hit2) begin
                    v2_q <= cdb_value_i;
                    q2_q <= '0;
                end
                if (shift_i && (state_q != ST_FREE) && (rank_q > shift_rank_i)) begin
                    rank_q <= rank_q - RANK_W'(1);
                end
            end
        end
    end

    p_alloc_only_free_r2: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_i |-> (state_q == ST_FREE));

    p_wait_has_tag_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAIT) |-> ((q1_q != '0) || (q2_q != '0)));

    p_grant_only_ready_r6: assert property (@(posedge clk) disable iff (!rst_n)
        grant_i |-> (state_q == ST_READY));

    p_retire_frees_r10: assert property (@(posedge clk) disable iff (!rst_n)
        retire_o |=> (state_q == ST_FREE));

endmodule

// File: rtl/rs_regstat.sv
module rs_regstat #(
    parameter int NUM_REGS = 8,
    parameter int REG_W    = 3,
    parameter int TAG_W    = 3,
    parameter int DATA_W   = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              iss_fire_i,
    input  logic [REG_W-1:0]  iss_dst_i,
    input  logic [TAG_W-1:0]  iss_tag_i,
    input  logic [REG_W-1:0]  src1_i,
    input  logic [REG_W-1:0]  src2_i,
    input  logic [DATA_W-1:0] rf1_i,
    input  logic [DATA_W-1:0] rf2_i,
    input  logic              cdb_valid_i,
    input  logic [TAG_W-1:0]  cdb_tag_i,
    input  logic [DATA_W-1:0] cdb_value_i,
    output logic [DATA_W-1:0] v1_o,
    output logic [TAG_W-1:0]  q1_o,
    output logic [DATA_W-1:0] v2_o,
    output logic [TAG_W-1:0]  q2_o,
    output logic              wr_en_o,
    output logic [REG_W-1:0]  wr_addr_o,
    output logic [DATA_W-1:0] wr_data_o
);

    logic [NUM_REGS-1:0][TAG_W-1:0] stat;

    for (genvar r = 0; r < NUM_REGS; r++) begin : g_stat
        logic [TAG_W-1:0] tag_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                tag_q <= '0;
            end else if (iss_fire_i && (iss_dst_i == REG_W'(r))) begin
                tag_q <= iss_tag_i;
            end else if (cdb_valid_i && (tag_q != '0) && (tag_q == cdb_tag_i)) begin
                tag_q <= '0;
            end
        end
        assign stat[r] = tag_q;
    end

    // source resolution with same-cycle bypass from the broadcast bus
    always_comb begin
        q1_o = stat[src1_i];
        v1_o = rf1_i;
        if (q1_o != '0) begin
            if (cdb_valid_i && (cdb_tag_i == q1_o)) begin
                v1_o = cdb_value_i;
                q1_o = '0;
            end else begin
                v1_o = '0;
            end
        end
        q2_o = stat[src2_i];
        v2_o = rf2_i;
        if (q2_o != '0) begin
            if (cdb_valid_i && (cdb_tag_i == q2_o)) begin
                v2_o = cdb_value_i;
                q2_o = '0;
            end else begin
                v2_o = '0;
            end
        end
    end

    // write-back only for the register whose latest producer is broadcasting
    always_comb begin
        wr_en_o   = 1'b0;
        wr_addr_o = '0;
        for (int r = 0; r < NUM_REGS; r++) begin
            if (cdb_valid_i && (stat[r] != '0) && (stat[r] == cdb_tag_i)) begin
                wr_en_o   = 1'b1;
                wr_addr_o = REG_W'(r);
            end
        end
        wr_data_o = cdb_value_i;
    end

    p_rename_dst_r8: assert property (@(posedge clk) disable iff (!rst_n)
        iss_fire_i |=> (stat[$past(iss_dst_i)] == $past(iss_tag_i)));

    p_clear_on_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_o && !(iss_fire_i && (iss_dst_i == wr_addr_o)))
        |=> (stat[$past(wr_addr_o)] == '0));

endmodule

// File: rtl/rs_pick.sv
module rs_pick #(
    parameter int N      = 4,
    parameter int RANK_W = 2,
    parameter int IDX_W  = 2
) (
    input  logic [N-1:0]             busy_i,
    input  logic [N-1:0]             ready_i,
    input  logic [N-1:0][RANK_W-1:0] rank_i,
    output logic                     alloc_ok_o,
    output logic [IDX_W-1:0]         alloc_idx_o,
    output logic                     grant_valid_o,
    output logic [IDX_W-1:0]         grant_idx_o,
    output logic [N-1:0]             grant_o
);

    // lowest-numbered free station
    always_comb begin
        alloc_ok_o  = 1'b0;
        alloc_idx_o = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (!busy_i[i]) begin
                alloc_ok_o  = 1'b1;
                alloc_idx_o = IDX_W'(i);
            end
        end
    end

    // oldest ready station: smallest age rank
    always_comb begin
        logic [RANK_W-1:0] best;
        best          = '0;
        grant_valid_o = 1'b0;
        grant_idx_o   = '0;
        for (int i = 0; i < N; i++) begin
            if (ready_i[i] && (!grant_valid_o || (rank_i[i] < best))) begin
                grant_valid_o = 1'b1;
                best          = rank_i[i];
                grant_idx_o   = IDX_W'(i);
            end
        end
        grant_o = '0;
        if (grant_valid_o) begin
            grant_o[grant_idx_o] = 1'b1;
        end
    end

endmodule

// File: rtl/rs_tag_array.sv
module rs_tag_array #(
    parameter int NUM_RS   = 4,
    parameter int NUM_REGS = 8,
    parameter int DATA_W   = 16,
    parameter int OP_W     = 2
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          iss_valid,
    input  logic [OP_W-1:0]               iss_op,
    input  logic [$clog2(NUM_REGS)-1:0]   iss_dst,
    input  logic [$clog2(NUM_REGS)-1:0]   iss_src1,
    input  logic [$clog2(NUM_REGS)-1:0]   iss_src2,
    input  logic [DATA_W-1:0]             iss_src1_val,
    input  logic [DATA_W-1:0]             iss_src2_val,
    output logic                          iss_stall,
    output logic [$clog2(NUM_RS+1)-1:0]   iss_tag,
    input  logic                          cdb_valid,
    input  logic [$clog2(NUM_RS+1)-1:0]   cdb_tag,
    input  logic [DATA_W-1:0]             cdb_value,
    output logic                          disp_valid,
    output logic [$clog2(NUM_RS+1)-1:0]   disp_tag,
    output logic [OP_W-1:0]               disp_op,
    output logic [DATA_W-1:0]             disp_a,
    output logic [DATA_W-1:0]             disp_b,
    output logic                          rf_we,
    output logic [$clog2(NUM_REGS)-1:0]   rf_waddr,
    output logic [DATA_W-1:0]             rf_wdata
);

    localparam int TAG_W  = $clog2(NUM_RS + 1);
    localparam int REG_W  = $clog2(NUM_REGS);
    localparam int IDX_W  = (NUM_RS > 1) ? $clog2(NUM_RS) : 1;
    localparam int RANK_W = IDX_W;
    localparam int CNT_W  = $clog2(NUM_RS + 1);

    logic [NUM_RS-1:0]              busy_vec, ready_vec, retire_vec, grant_vec;
    logic [NUM_RS-1:0][RANK_W-1:0]  rank_vec;
    logic [NUM_RS-1:0][OP_W-1:0]    op_vec;
    logic [NUM_RS-1:0][DATA_W-1:0]  a_vec, b_vec;
    logic                           alloc_ok, grant_valid, iss_fire;
    logic [IDX_W-1:0]               alloc_idx, grant_idx;
    logic [DATA_W-1:0]              rv1, rv2;
    logic [TAG_W-1:0]               rq1, rq2;
    logic [CNT_W-1:0]               occ;
    logic                           ret_any;
    logic [RANK_W-1:0]              ret_rank, new_rank;

    assign iss_fire  = iss_valid && alloc_ok;
    assign iss_stall = !alloc_ok;
    assign iss_tag   = TAG_W'(alloc_idx) + TAG_W'(1);

    // age rank handed to a new station: count of survivors
    always_comb begin
        occ      = CNT_W'($countones(busy_vec));
        ret_any  = |retire_vec;
        ret_rank = '0;
        for (int i = 0; i < NUM_RS; i++) begin
            if (retire_vec[i]) begin
                ret_rank = rank_vec[i];
            end
        end
        new_rank = RANK_W'(occ - (ret_any ? CNT_W'(1) : CNT_W'(0)));
    end

    rs_regstat #(
        .NUM_REGS (NUM_REGS),
        .REG_W    (REG_W),
        .TAG_W    (TAG_W),
        .DATA_W   (DATA_W)
    ) u_regstat (
        .clk         (clk),
        .rst_n       (rst_n),
        .iss_fire_i  (iss_fire),
        .iss_dst_i   (iss_dst),
        .iss_tag_i   (iss_tag),
        .src1_i      (iss_src1),
        .src2_i      (iss_src2),
        .rf1_i       (iss_src1_val),
        .rf2_i       (iss_src2_val),
        .cdb_valid_i (cdb_valid),
        .cdb_tag_i   (cdb_tag),
        .cdb_value_i (cdb_value),
        .v1_o        (rv1),
        .q1_o        (rq1),
        .v2_o        (rv2),
        .q2_o        (rq2),
        .wr_en_o     (rf_we),
        .wr_addr_o   (rf_waddr),
        .wr_data_o   (rf_wdata)
    );

    for (genvar i = 0; i < NUM_RS; i++) begin : g_slot
        rs_station #(
            .TAG_W  (TAG_W),
            .DATA_W (DATA_W),
            .OP_W   (OP_W),
            .RANK_W (RANK_W),
            .MY_TAG (i + 1)
        ) u_slot (
            .clk          (clk),
            .rst_n        (rst_n),
            .alloc_i      (iss_fire && (alloc_idx == IDX_W'(i))),
            .op_i         (iss_op),
            .v1_i         (rv1),
            .q1_i         (rq1),
            .v2_i         (rv2),
            .q2_i         (rq2),
            .rank_i       (new_rank),
            .cdb_valid_i  (cdb_valid),
            .cdb_tag_i    (cdb_tag),
            .cdb_value_i  (cdb_value),
            .grant_i      (grant_vec[i]),
            .shift_i      (ret_any),
            .shift_rank_i (ret_rank),
            .busy_o       (busy_vec[i]),
            .ready_o      (ready_vec[i]),
            .retire_o     (retire_vec[i]),
            .rank_o       (rank_vec[i]),
            .op_o         (op_vec[i]),
            .v1_o         (a_vec[i]),
            .v2_o         (b_vec[i])
        );
    end

    rs_pick #(
        .N      (NUM_RS),
        .RANK_W (RANK_W),
        .IDX_W  (IDX_W)
    ) u_pick (
        .busy_i        (busy_vec),
        .ready_i       (ready_vec),
        .rank_i        (rank_vec),
        .alloc_ok_o    (alloc_ok),
        .alloc_idx_o   (alloc_idx),
        .grant_valid_o (grant_valid),
        .grant_idx_o   (grant_idx),
        .grant_o       (grant_vec)
    );

    always_comb begin
        disp_valid = grant_valid;
        disp_tag   = TAG_W'(grant_idx) + TAG_W'(1);
        disp_op    = op_vec[grant_idx];
        disp_a     = a_vec[grant_idx];
        disp_b     = b_vec[grant_idx];
    end

    // checker-side view: is any ready station older than the granted one
    logic older_ready;
    always_comb begin
        older_ready = 1'b0;
        for (int i = 0; i < NUM_RS; i++) begin
            if (ready_vec[i] && (rank_vec[i] < rank_vec[grant_idx])) begin
                older_ready = 1'b1;
            end
        end
    end

    p_stall_when_full_r2: assert property (@(posedge clk) disable iff (!rst_n)
        iss_stall |-> (&busy_vec));

    p_grant_onehot_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant_vec));

    p_oldest_first_r7: assert property (@(posedge clk) disable iff (!rst_n)
        disp_valid |-> !older_ready);

    p_single_retire_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(retire_vec));

    p_retire_needs_bcast_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (|retire_vec) |-> cdb_valid);

endmodule

// File: tb/test_rs_tag_array.sv
module test_rs_tag_array;

    localparam int CLK_PERIOD = 10;
    localparam int NRS   = 4;
    localparam int NREG  = 8;
    localparam int DW    = 16;
    localparam int OPW   = 2;
    localparam int MAXI  = 1024;
    localparam int HOLD  = 1000000;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           iss_valid = 1'b0;
    logic [1:0]     iss_op = '0;
    logic [2:0]     iss_dst = '0, iss_src1 = '0, iss_src2 = '0;
    logic [DW-1:0]  iss_src1_val = '0, iss_src2_val = '0;
    logic           iss_stall;
    logic [2:0]     iss_tag;
    logic           cdb_valid = 1'b0;
    logic [2:0]     cdb_tag = '0;
    logic [DW-1:0]  cdb_value = '0;
    logic           disp_valid;
    logic [2:0]     disp_tag;
    logic [1:0]     disp_op;
    logic [DW-1:0]  disp_a, disp_b;
    logic           rf_we;
    logic [2:0]     rf_waddr;
    logic [DW-1:0]  rf_wdata;

    always #(CLK_PERIOD / 2) clk = ~clk;

    rs_tag_array #(
        .NUM_RS(NRS), .NUM_REGS(NREG), .DATA_W(DW), .OP_W(OPW)
    ) i_rs_tag_array (
        .clk(clk), .rst_n(rst_n),
        .iss_valid(iss_valid), .iss_op(iss_op), .iss_dst(iss_dst),
        .iss_src1(iss_src1), .iss_src2(iss_src2),
        .iss_src1_val(iss_src1_val), .iss_src2_val(iss_src2_val),
        .iss_stall(iss_stall), .iss_tag(iss_tag),
        .cdb_valid(cdb_valid), .cdb_tag(cdb_tag), .cdb_value(cdb_value),
        .disp_valid(disp_valid), .disp_tag(disp_tag), .disp_op(disp_op),
        .disp_a(disp_a), .disp_b(disp_b),
        .rf_we(rf_we), .rf_waddr(rf_waddr), .rf_wdata(rf_wdata)
    );

    int n_chk = 0, n_bad = 0;
    bit done = 0;

    // program, reference model and register file
    int            p_op [MAXI], p_dst [MAXI], p_s1 [MAXI], p_s2 [MAXI];
    logic [DW-1:0] exp_a [MAXI], exp_b [MAXI], exp_r [MAXI];
    int            prog_n = 0, iss_ptr = 0;
    logic [DW-1:0] rf [NREG], refm [NREG];
    int            tag2idx [NRS+1];
    bit            fl_valid [NRS+1];
    logic [DW-1:0] fl_res [NRS+1];
    int            fl_cnt [NRS+1];
    int            lat_max = 0;
    int unsigned   seed = 32'h1234_5678;

    int last_stall, last_iss_tag, last_dv, last_dtag, last_we, last_waddr, last_wdata;

    function automatic logic [DW-1:0] alu(input int op, input logic [DW-1:0] a, input logic [DW-1:0] b);
        case (op)
            0: return a + b;
            1: return a - b;
            2: return a ^ b;
            default: return a | b;
        endcase
    endfunction

    function automatic int rnd();
        seed ^= seed << 13;
        seed ^= seed >> 17;
        seed ^= seed << 5;
        return int'(seed & 32'h7fff_ffff);
    endfunction

    task automatic chk(input string req, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic add_instr(input int op, input int dst, input int s1, input int s2);
        p_op[prog_n] = op; p_dst[prog_n] = dst; p_s1[prog_n] = s1; p_s2[prog_n] = s2;
        prog_n++;
    endtask

    // one clock cycle; bc: 0 none, -1 automatic, >0 that tag
    task automatic cycle(input bit do_iss, input int bc);
        int sel = 0;
        bit issuing;
        int wa = 0;
        logic [DW-1:0] wd = '0;
        bit wr = 0;
        if (bc > 0) begin
            if (!fl_valid[bc]) begin
                n_chk++; n_bad++;
                $display("FAIL R10 broadcast of tag %0d not in flight actual=0 expected=1", bc);
            end else sel = bc;
        end else if (bc < 0) begin
            for (int t = 1; t <= NRS; t++)
                if (sel == 0 && fl_valid[t] && fl_cnt[t] <= 0) sel = t;
        end
        cdb_valid = (sel != 0);
        cdb_tag   = 3'(sel);
        cdb_value = (sel != 0) ? fl_res[sel] : '0;
        issuing = do_iss && (iss_ptr < prog_n);
        iss_valid = issuing;
        if (issuing) begin
            iss_op   = 2'(p_op[iss_ptr]);
            iss_dst  = 3'(p_dst[iss_ptr]);
            iss_src1 = 3'(p_s1[iss_ptr]);
            iss_src2 = 3'(p_s2[iss_ptr]);
            iss_src1_val = rf[p_s1[iss_ptr]];
            iss_src2_val = rf[p_s2[iss_ptr]];
        end
        #1;
        last_stall = iss_stall; last_iss_tag = iss_tag;
        last_dv = disp_valid; last_dtag = disp_tag;
        last_we = rf_we; last_waddr = rf_waddr; last_wdata = rf_wdata;
        if (issuing && !iss_stall) begin
            int k = iss_ptr;
            exp_a[k] = refm[p_s1[k]];
            exp_b[k] = refm[p_s2[k]];
            exp_r[k] = alu(p_op[k], exp_a[k], exp_b[k]);
            refm[p_dst[k]] = exp_r[k];
            tag2idx[iss_tag] = k;
            iss_ptr++;
        end
        if (sel != 0) fl_valid[sel] = 0;
        if (disp_valid) begin
            int k = tag2idx[disp_tag];
            chk("R6 dispatch op", disp_op, p_op[k]);
            chk("R3 R4 dispatch operand a", disp_a, exp_a[k]);
            chk("R3 R4 dispatch operand b", disp_b, exp_b[k]);
            fl_valid[disp_tag] = 1;
            fl_res[disp_tag] = alu(int'(disp_op), disp_a, disp_b);
            fl_cnt[disp_tag] = (lat_max == 0) ? HOLD : 1 + (rnd() % lat_max);
        end
        if (rf_we) begin wr = 1; wa = rf_waddr; wd = rf_wdata; end
        @(posedge clk);
        if (wr) rf[wa] = wd;
        for (int t = 1; t <= NRS; t++) if (fl_valid[t]) fl_cnt[t]--;
        @(negedge clk);
        iss_valid = 1'b0;
        cdb_valid = 1'b0;
    endtask

    task automatic drain();
        repeat (24) begin
            for (int t = 1; t <= NRS; t++) if (fl_valid[t]) fl_cnt[t] = 0;
            cycle(1, -1);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        for (int r = 0; r < NREG; r++) begin
            rf[r] = DW'(r * 17 + 3);
            refm[r] = rf[r];
        end
        for (int t = 0; t <= NRS; t++) begin fl_valid[t] = 0; tag2idx[t] = 0; fl_cnt[t] = 0; end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1 reset state
        chk("R1 stall after reset", iss_stall, 0);
        chk("R1 dispatch idle after reset", disp_valid, 0);
        chk("R1 no write after reset", rf_we, 0);
        chk("R1 first tag after reset", iss_tag, 1);
        @(negedge clk);

        // R5 and R8: consumer issues in the producer's broadcast cycle
        add_instr(0, 1, 2, 3);
        cycle(1, 0);
        chk("R2 first issue tag", last_iss_tag, 1);
        cycle(0, 0);
        chk("R6 producer dispatched", last_dtag, 1);
        add_instr(2, 4, 1, 1);
        cycle(1, 1);
        chk("R2 tag while station 0 retires", last_iss_tag, 2);
        chk("R9 producer writes r1", last_we, 1);
        chk("R9 write address", last_waddr, 1);
        cycle(0, 0);
        chk("R5 bypassed consumer dispatched next cycle", last_dv, 1);
        chk("R5 bypassed consumer tag", last_dtag, 2);
        chk("R8 renamed source value", exp_a[1], alu(0, DW'(2*17+3), DW'(3*17+3)));
        drain();

        // R2 and R10: fill every station, stall, free one, reuse it
        for (int i = 0; i < NRS; i++) add_instr(1, 2 + i, 0, 7);
        for (int i = 0; i < NRS; i++) cycle(1, 0);
        cycle(0, 0);
        chk("R2 stall when full", last_stall, 1);
        add_instr(3, 6, 1, 0);
        cycle(1, 0);
        chk("R2 stall holds issue", last_stall, 1);
        cycle(1, 3);
        chk("R10 still full in broadcast cycle", last_stall, 1);
        cycle(1, 0);
        chk("R10 freed station reused", last_stall, 0);
        chk("R10 reused tag", last_iss_tag, 3);
        drain();

        // R9: two producers of r5, younger broadcasts first
        add_instr(0, 5, 1, 2);
        add_instr(1, 5, 3, 4);
        cycle(1, 0);
        cycle(1, 0);
        cycle(0, 0);
        cycle(0, 2);
        chk("R9 latest producer writes", last_we, 1);
        chk("R9 latest producer address", last_waddr, 5);
        chk("R9 latest producer data", last_wdata, exp_r[prog_n - 1]);
        cycle(0, 1);
        chk("R9 older producer suppressed", last_we, 0);
        add_instr(0, 6, 5, 5);
        cycle(1, 0);
        cycle(0, 0);
        chk("R9 reader sees younger value", last_dv, 1);
        drain();

        // R7: younger station in a lower slot, both wake together
        add_instr(0, 6, 1, 1);
        add_instr(0, 7, 2, 2);
        add_instr(2, 0, 7, 3);
        add_instr(3, 2, 7, 4);
        cycle(1, 0);
        cycle(1, 0);
        cycle(1, 0);
        chk("R2 third tag", last_iss_tag, 3);
        cycle(0, 1);
        chk("R6 waiting station not dispatched", last_dv, 0);
        cycle(1, 0);
        chk("R2 reused lowest slot", last_iss_tag, 1);
        chk("R6 no dispatch while waiting", last_dv, 0);
        cycle(0, 2);
        chk("R4 capture cycle has no dispatch", last_dv, 0);
        cycle(0, 0);
        chk("R7 oldest first", last_dtag, 3);
        cycle(0, 0);
        chk("R7 younger second", last_dtag, 1);
        drain();

        // R11: sweeps over result latency with random streams
        for (int lm = 1; lm <= 7; lm += 3) begin
            lat_max = lm;
            for (int i = 0; i < 150; i++)
                add_instr(rnd() % 4, rnd() % NREG, rnd() % NREG, rnd() % NREG);
            while (iss_ptr < prog_n) cycle(1, -1);
            drain();
        end
        chk("R11 all issued", iss_ptr, prog_n);
        for (int r = 0; r < NREG; r++) chk("R11 final register", rf[r], refm[r]);
        finish_run();
    end

endmodule